// File: doc/BRIEF.md
# Multi-Mode Global Interrupt Distributor

This block collects a parameterised set of system interrupt inputs and distributes them to a small cluster of CPUs. Each input is first passed through a two-flop synchroniser. A per-source trigger mode then turns it into a pending state. The mode is one of active-high level, active-low level, rising edge, falling edge or both edges. Edge-derived pending bits are sticky until software clears them. Level-derived pending state simply follows the corrected input.

Each source has an enable bit, a target CPU number and a flag that sends it to the target's non-maskable line instead of its normal interrupt line. Software can also post inter-processor interrupts to any CPU through a set/clear register pair. All configuration and status sit behind a simple word-addressed read/write port.

Top module: `irq_distributor`

## Requirements
- R1: Each source input passes through two synchronising flops. A level change on `src_i` appears on `irq_o` after exactly two rising clock edges, and not after one.
- R2: Trigger code 0 makes a source pending while its input is 1. Code 1 makes it pending while its input is 0. Level pending state is never latched and drops as soon as the synchronised input goes inactive.
- R3: Code 2 sets a sticky pending bit on a synchronised 0-to-1 change, code 3 on a 1-to-0 change, and code 4 on either. For an edge driven before a rising edge, the bit is visible after the third rising edge.
- R4: Writing region 2 clears edge pending bits. Bit b of word w clears source 32*w+b when b is 1. Zero bits have no effect, and a clear on a level-mode source has no effect.
- R5: Region 1 word w, bit b is the enable of source 32*w+b. A disabled source never drives `irq_o`, but its pending bit is still set and readable. All enables are 0 after reset.
- R6: A source that is enabled, pending and not flagged as NMI drives `irq_o[t]`, where t is field [8 +: CPU_W] of its configuration word.
- R7: Bit 3 of a source's configuration word sends its pending state to `nmi_o[t]` regardless of its enable. Such a source never drives `irq_o`.
- R8: A write to region 3 index 0 sets inter-processor pending bits (bit c for CPU c). A write to index 1 clears the bits written as 1. Each such bit ORs into `irq_o[c]`, and both indices read back the bits.
- R9: The address is {region[1:0], index[7:0]}. Region 0 index s holds the configuration of source s: mode in [2:0], NMI flag in [3], target in [8 +: CPU_W]. A read presents its word on `rdata_o` after the next rising edge, and `rdata_o` is held until the next read.
- R10: After reset `irq_o` and `nmi_o` are 0 and every configuration word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt source inputs |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | {region, index} word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read |
| irq_o | output | NUM_CPU | Per-CPU interrupt lines |
| nmi_o | output | NUM_CPU | Per-CPU non-maskable interrupt lines |

## Verification
The in-line assertions check on every cycle three kinds of behaviour. A detected edge in an edge mode always sets the pending bit, and a set edge bit survives every cycle without a matching clear. The inter-processor bits change only on their own writes, and the read data moves only after a read. Synchroniser latency, the polarity of each mode, the enable and NMI routing to the chosen CPU, and the ignored clears on level sources depend on sequences of inputs and register writes. Only the directed scenarios in the bench can show these.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [2:0] {
    TRIG_LVL_HI = 3'd0,
    TRIG_LVL_LO = 3'd1,
    TRIG_RISE   = 3'd2,
    TRIG_FALL   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  typedef enum logic [1:0] {
    RGN_CFG  = 2'd0,
    RGN_EN   = 2'd1,
    RGN_PEND = 2'd2,
    RGN_IPI  = 2'd3
  } region_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/irqd_src_cell.sv
module irqd_src_cell
  import irqd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_i,
  input  logic [2:0] mode_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic s1_q, s2_q, s3_q, pend_q;
  logic rise, fall, is_edge, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    is_edge = 1'b0;
    hit     = 1'b0;
    case (mode_i)
      TRIG_RISE: begin is_edge = 1'b1; hit = rise; end
      TRIG_FALL: begin is_edge = 1'b1; hit = fall; end
      TRIG_BOTH: begin is_edge = 1'b1; hit = rise | fall; end
      default: ;
    endcase
  end

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (!is_edge) pend_q <= 1'b0;
    else if (hit)      pend_q <= 1'b1;
    else if (clr_i)    pend_q <= 1'b0;
  end

  always_comb begin
    case (mode_i)
      TRIG_LVL_HI: pend_o = s2_q;
      TRIG_LVL_LO: pend_o = ~s2_q;
      TRIG_RISE, TRIG_FALL, TRIG_BOTH: pend_o = pend_q;
      default: pend_o = 1'b0;
    endcase
  end

  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (pend_q || !is_edge)); // R3
  AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> (pend_q || !is_edge)); // R4
endmodule

// File: rtl/irqd_route.sv
module irqd_route #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CPU_W   = 2
) (
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0]            en_i,
  input  logic [NUM_SRC-1:0]            nmi_sel_i,
  input  logic [NUM_SRC-1:0][CPU_W-1:0] tgt_i,
  input  logic [NUM_CPU-1:0]            ipi_i,
  output logic [NUM_CPU-1:0]            irq_o,
  output logic [NUM_CPU-1:0]            nmi_o
);
  always_comb begin
    irq_o = ipi_i;
    nmi_o = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (tgt_i[s] == CPU_W'(c)) begin
          if (nmi_sel_i[s]) nmi_o[c] = nmi_o[c] | pend_i[s];
          else              irq_o[c] = irq_o[c] | (pend_i[s] & en_i[s]);
        end
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned IDX_W   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_SRC-1:0]      src_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [IDX_W+1:0]        addr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [WORD_W-1:0]       rdata_o,
  output logic [NUM_CPU-1:0]      irq_o,
  output logic [NUM_CPU-1:0]      nmi_o
);
  localparam int unsigned CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int unsigned ADDR_W = IDX_W + 2;

  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;

  assign region = addr_i[ADDR_W-1 -: 2];
  assign idx    = addr_i[IDX_W-1:0];
  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;

  logic [NUM_SRC-1:0][2:0]       mode_q;
  logic [NUM_SRC-1:0]            nmi_q;
  logic [NUM_SRC-1:0][CPU_W-1:0] tgt_q;
  logic [NUM_SRC-1:0]            en_q;
  logic [NUM_SRC-1:0]            clr;
  logic [NUM_SRC-1:0]            pend;
  logic [NUM_CPU-1:0]            ipi_q;
  logic [WORD_W-1:0]             rmux, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      nmi_q  <= '0;
      tgt_q  <= '0;
      en_q   <= '0;
    end else if (wr) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (region == RGN_CFG && idx == IDX_W'(s)) begin
          mode_q[s] <= wdata_i[2:0];
          nmi_q[s]  <= wdata_i[3];
          tgt_q[s]  <= wdata_i[8 +: CPU_W];
        end
        if (region == RGN_EN && idx == IDX_W'(s / WORD_W))
          en_q[s] <= wdata_i[s % WORD_W];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++)
      clr[s] = wr && region == RGN_PEND && idx == IDX_W'(s / WORD_W) && wdata_i[s % WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ipi_q <= '0;
    else if (wr && region == RGN_IPI) begin
      if (idx == IDX_W'(0))      ipi_q <= ipi_q | wdata_i[NUM_CPU-1:0];
      else if (idx == IDX_W'(1)) ipi_q <= ipi_q & ~wdata_i[NUM_CPU-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irqd_src_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[g]),
      .mode_i (mode_q[g]),
      .clr_i  (clr[g]),
      .pend_o (pend[g])
    );
  end

  irqd_route #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
  ) u_route (
    .pend_i    (pend),
    .en_i      (en_q),
    .nmi_sel_i (nmi_q),
    .tgt_i     (tgt_q),
    .ipi_i     (ipi_q),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o)
  );

  always_comb begin
    rmux = '0;
    case (region)
      RGN_CFG: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (idx == IDX_W'(s)) begin
            rmux[2:0]         = mode_q[s];
            rmux[3]           = nmi_q[s];
            rmux[8 +: CPU_W]  = tgt_q[s];
          end
        end
      end
      RGN_EN: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (idx == IDX_W'(s / WORD_W)) rmux[s % WORD_W] = en_q[s];
      end
      RGN_PEND: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (idx == IDX_W'(s / WORD_W)) rmux[s % WORD_W] = pend[s];
      end
      default: rmux[NUM_CPU-1:0] = ipi_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;

  AST_IPI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && region == RGN_IPI && idx == IDX_W'(0))
      |=> ((ipi_q & $past(wdata_i[NUM_CPU-1:0])) == $past(wdata_i[NUM_CPU-1:0]))); // R8
  AST_IPI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && region == RGN_IPI) |=> $stable(ipi_q)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o)); // R9
  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && region == RGN_CFG && idx == IDX_W'(0))
      |=> (nmi_q[0] == $past(wdata_i[3]))); // R7
endmodule

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NC-1:0] irq, nmi;

  int checks = 0, errors = 0;
  logic [31:0] en_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_distributor #(.NUM_SRC(NS), .NUM_CPU(NC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .nmi_o(nmi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] rg, input logic [7:0] ix, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = {rg, ix}; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] rg, input logic [7:0] ix, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = {rg, ix};
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic set_cfg(input int s, input int mode, input bit nm, input int tgt);
    reg_wr(2'd0, 8'(s), 32'((tgt << 8) | (int'(nm) << 3) | mode));
  endtask

  task automatic enable(input int s);
    en_word[s] = 1'b1;
    reg_wr(2'd1, 8'd0, en_word);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R10 irq after reset", 32'(irq), 0);
    chk("R10 nmi after reset", 32'(nmi), 0);
    reg_rd(2'd0, 8'd5, d);
    chk("R10 cfg word reset", d, 0);
    reg_rd(2'd1, 8'd0, d);
    chk("R5 enables reset", d, 0);
  endtask

  task automatic t_level;
    set_cfg(0, 0, 0, 1);
    enable(0);
    src[0] = 1'b1;
    wait_clk(1);
    chk("R1 one edge not enough", 32'(irq[1]), 0);
    wait_clk(1);
    chk("R1 visible after two edges", 32'(irq[1]), 1);
    chk("R6 routed only to cpu1", 32'(irq), 32'b0010);
    src[0] = 1'b0;
    wait_clk(2);
    chk("R2 level high drops, no latch", 32'(irq), 0);
    set_cfg(2, 1, 0, 0);
    enable(2);
    wait_clk(1);
    chk("R2 level low pending at 0", 32'(irq), 32'b0001);
    src[2] = 1'b1;
    wait_clk(2);
    chk("R2 level low inactive at 1", 32'(irq), 0);
    src[2] = 1'b0;
    set_cfg(2, 0, 0, 0);
  endtask

  task automatic t_edge;
    set_cfg(3, 2, 0, 2);
    enable(3);
    src[3] = 1'b1;
    wait_clk(2);
    chk("R3 rise not yet pending", 32'(irq[2]), 0);
    wait_clk(1);
    chk("R3 rise pending at third edge", 32'(irq), 32'b0100);
    src[3] = 1'b0;
    wait_clk(4);
    chk("R3 rise pending is sticky", 32'(irq[2]), 1);
    reg_wr(2'd2, 8'd0, 32'd0);
    chk("R4 zero clear has no effect", 32'(irq[2]), 1);
    reg_wr(2'd2, 8'd0, 32'h8);
    chk("R4 write-1 clears edge", 32'(irq[2]), 0);

    set_cfg(4, 3, 0, 3);
    enable(4);
    src[4] = 1'b1;
    wait_clk(4);
    chk("R3 fall ignores rise", 32'(irq[3]), 0);
    src[4] = 1'b0;
    wait_clk(4);
    chk("R3 fall pending", 32'(irq[3]), 1);
    reg_wr(2'd2, 8'd0, 32'h10);
    chk("R4 clear fall", 32'(irq[3]), 0);

    set_cfg(5, 4, 0, 1);
    enable(5);
    src[5] = 1'b1;
    wait_clk(4);
    chk("R3 both on rise", 32'(irq[1]), 1);
    reg_wr(2'd2, 8'd0, 32'h20);
    chk("R4 clear both", 32'(irq[1]), 0);
    src[5] = 1'b0;
    wait_clk(4);
    chk("R3 both on fall", 32'(irq[1]), 1);
    reg_wr(2'd2, 8'd0, 32'h20);
    chk("R4 clear both again", 32'(irq[1]), 0);

    src[0] = 1'b1;
    wait_clk(3);
    reg_wr(2'd2, 8'd0, 32'h1);
    chk("R4 clear ignored on level", 32'(irq[1]), 1);
    src[0] = 1'b0;
    wait_clk(3);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    set_cfg(6, 2, 0, 0);
    src[6] = 1'b1;
    wait_clk(4);
    chk("R5 disabled source silent", 32'(irq), 0);
    reg_rd(2'd2, 8'd0, d);
    chk("R5 disabled still pending", d, 32'h40);
    enable(6);
    chk("R5 enable exposes pending", 32'(irq), 32'b0001);
    reg_wr(2'd2, 8'd0, 32'h40);
    chk("R4 clear src6", 32'(irq), 0);
    src[6] = 1'b0;
    wait_clk(3);
  endtask

  task automatic t_nmi;
    set_cfg(7, 0, 1, 2);
    src[7] = 1'b1;
    wait_clk(3);
    chk("R7 nmi ignores enable", 32'(nmi), 32'b0100);
    chk("R7 nmi not on irq", 32'(irq), 0);
    enable(7);
    chk("R7 enabled nmi still not irq", 32'(irq), 0);
    src[7] = 1'b0;
    wait_clk(3);
    chk("R7 nmi follows level", 32'(nmi), 0);
  endtask

  task automatic t_ipi;
    logic [31:0] d;
    reg_wr(2'd3, 8'd0, 32'b0101);
    chk("R8 ipi sets", 32'(irq), 32'b0101);
    reg_rd(2'd3, 8'd0, d);
    chk("R8 ipi readback", d, 32'b0101);
    reg_wr(2'd3, 8'd1, 32'b0001);
    chk("R8 ipi clear one", 32'(irq), 32'b0100);
    reg_rd(2'd3, 8'd1, d);
    chk("R8 ipi readback idx1", d, 32'b0100);
    reg_wr(2'd3, 8'd1, 32'hF);
    chk("R8 ipi all clear", 32'(irq), 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    set_cfg(9, 4, 1, 3);
    reg_rd(2'd0, 8'd9, d);
    chk("R9 cfg readback", d, 32'h30C);
    reg_wr(2'd0, 8'd10, 32'h0);
    chk("R9 rdata held over write", rdata, 32'h30C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    t_reset();
    t_level();
    t_edge();
    t_mask();
    t_nmi();
    t_ipi();
    t_readback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule